// File: doc/BRIEF.md
# GPIO Level-Sense, Sticky Latch and Edge-Event Bank

This block serves a bank of general-purpose pins. Each pin has its own configuration word that sets its direction, a level-sense mode (off, high or low) and an edge selection for event generation (none, rising, falling or either). Pin inputs are first brought into the clock domain by a synchronizer. Detection of levels and edges then runs on the synchronized values. A level that matches a pin's sense setting sets that pin's bit in a sticky latch register. The matches also drive a single detect output, which a power controller can use as a wake-up request.

Edges produce a one-cycle event pulse for each pin. Each pulse also sets a pending flag. The pending flags, gated by an enable mask, form one interrupt request. Each output bit comes from a data register, but it can also be set, cleared or toggled by per-pin task inputs from an event-routing fabric. Software reaches every register through a small word-addressed bus, with a write strobe and a combinational read port.

Top module: `gpio_sense_unit`

## Requirements
- R1: While `rst` is high and after its release with no writes, `pin_out`, `pin_oe`, `evt_pulse`, `detect`, `irq` are 0, and every register reads 0.
- R2: A change on `pin_in` becomes visible in the input register (address 1) after exactly two rising clock edges.
- R3: In direct detect mode, `detect` is the OR over all pins of the sense matches on the synchronized inputs. Sense code 1 matches a high level and code 2 matches a low level. Codes 0 and 3 never match, never set a latch bit and never raise `detect`.
- R4: A sense match sets the pin's bit in the latch register (address 2) on the next edge. The bit stays set after the match ends.
- R5: Writing 1 to a latch bit clears it, and writing 0 has no effect. If the pin still matches in the cycle of the write, the bit is set again on that same edge.
- R6: With the mode register (address 5, bit 0) set to 1, `detect` is the OR of the latch register bits.
- R7: Edge code 1 gives a one-cycle `evt_pulse` on a synchronized rising edge. Code 2 does so on a falling edge, code 3 on either edge, and code 0 never.
- R8: Each event pulse sets a pending flag (address 3) on the next edge. Writing 1 clears a flag. A new pulse in the same cycle wins over the clear.
- R9: `irq` is the OR of the pending flags ANDed with the enable register (address 4).
- R10: `pin_oe` follows the direction bit. `pin_out` comes from the output register (address 0). For each bit, a task input overrides a bus write in the same cycle. Set has priority over clear, and clear has priority over toggle.
- R11: The configuration word of pin p is at address 32+p. Bit 0 is direction, bits 2:1 are the sense code and bits 4:3 are the edge code. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| task_set | input | NUM_PINS | Per-pin set-output task |
| task_clr | input | NUM_PINS | Per-pin clear-output task |
| task_tgl | input | NUM_PINS | Per-pin toggle-output task |
| evt_pulse | output | NUM_PINS | One-cycle edge events |
| detect | output | 1 | Wake-up / sense detect |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a latch clear written in the very cycle where the pin still matches, so that the bit must come back at once. The same cycle-exact difficulty applies to an edge event that lands together with a clear of its pending flag. The stimulus reaches these cases in two ways. Directed sequences hold a level and write clears at fixed offsets from the pin change. A long random phase flips a few pins at a time while clears, configuration and task writes arrive at random. A cycle-level model then judges every output and read value in every cycle.

// File: rtl/gsu_pkg.sv
package gsu_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned OFS_OUT   = 0;
    localparam int unsigned OFS_IN    = 1;
    localparam int unsigned OFS_LATCH = 2;
    localparam int unsigned OFS_EVT   = 3;
    localparam int unsigned OFS_INTEN = 4;
    localparam int unsigned OFS_MODE  = 5;
    localparam int unsigned OFS_CFG   = 32;

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_LOW  = 2'd2,
        SENSE_RSVD = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_e;

    typedef enum logic {
        DET_DIRECT  = 1'b0,
        DET_LATCHED = 1'b1
    } det_mode_e;

    typedef struct packed {
        edge_e  edge_sel;
        sense_e sense;
        logic   dir;
    } pin_cfg_t;

    localparam int unsigned CFG_W = $bits(pin_cfg_t);

    function automatic logic sense_hit(sense_e mode, logic lvl);
        case (mode)
            SENSE_HIGH: return lvl;
            SENSE_LOW:  return !lvl;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic edge_hit(edge_e sel, logic cur, logic prv);
        case (sel)
            EDGE_RISE: return cur && !prv;
            EDGE_FALL: return !cur && prv;
            EDGE_ANY:  return cur != prv;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gsu_sync.sv
module gsu_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gsu_pin.sv
module gsu_pin
    import gsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     lvl,
    input  logic     wr_out,
    input  logic     wr_val,
    input  logic     t_set,
    input  logic     t_clr,
    input  logic     t_tgl,
    output logic     match,
    output logic     evt,
    output logic     out_q
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (t_set)       out_q <= 1'b1;
            else if (t_clr)  out_q <= 1'b0;
            else if (t_tgl)  out_q <= ~out_q;
            else if (wr_out) out_q <= wr_val;
        end
    end

    assign match = sense_hit(cfg.sense, lvl);
    assign evt   = edge_hit(cfg.edge_sel, lvl, prev_q);

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (evt && cfg.edge_sel == EDGE_RISE) |-> (lvl && !$past(lvl))); // R7
    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (evt && cfg.edge_sel == EDGE_FALL) |-> (!lvl && $past(lvl))); // R7
    AST_TASK_SET: assert property (@(posedge clk) disable iff (rst)
        t_set |=> out_q); // R10
    AST_TASK_CLR: assert property (@(posedge clk) disable iff (rst)
        (t_clr && !t_set) |=> !out_q); // R10

endmodule

// File: rtl/gpio_sense_unit.sv
module gpio_sense_unit
    import gsu_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] task_set,
    input  logic [NUM_PINS-1:0] task_clr,
    input  logic [NUM_PINS-1:0] task_tgl,
    output logic [NUM_PINS-1:0] evt_pulse,
    output logic                detect,
    output logic                irq
);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFS_LATCH);
    localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(OFS_EVT);
    localparam logic [ADDR_W-1:0] A_INTEN = ADDR_W'(OFS_INTEN);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] match_v;
    logic [NUM_PINS-1:0] evt_v;
    logic [NUM_PINS-1:0] out_v;
    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] evt_q;
    logic [NUM_PINS-1:0] inten_q;
    logic [NUM_PINS-1:0] latch_clr;
    logic [NUM_PINS-1:0] evt_clr;
    det_mode_e           mode_q;
    pin_cfg_t            cfg_q [NUM_PINS];

    logic wr_out, wr_latch, wr_evt, wr_inten, wr_mode;

    assign wr_out   = bus_we && (bus_addr == A_OUT);
    assign wr_latch = bus_we && (bus_addr == A_LATCH);
    assign wr_evt   = bus_we && (bus_addr == A_EVT);
    assign wr_inten = bus_we && (bus_addr == A_INTEN);
    assign wr_mode  = bus_we && (bus_addr == A_MODE);

    assign latch_clr = wr_latch ? bus_wdata[NUM_PINS-1:0] : '0;
    assign evt_clr   = wr_evt   ? bus_wdata[NUM_PINS-1:0] : '0;

    gsu_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_lvl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic cfg_wr;
        assign cfg_wr = bus_we && (bus_addr == ADDR_W'(OFS_CFG + p));

        always_ff @(posedge clk) begin
            if (rst)         cfg_q[p] <= '0;
            else if (cfg_wr) cfg_q[p] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
        end

        gsu_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg_q[p]),
            .lvl    (sync_lvl[p]),
            .wr_out (wr_out),
            .wr_val (bus_wdata[p]),
            .t_set  (task_set[p]),
            .t_clr  (task_clr[p]),
            .t_tgl  (task_tgl[p]),
            .match  (match_v[p]),
            .evt    (evt_v[p]),
            .out_q  (out_v[p])
        );

        assign pin_oe[p] = cfg_q[p].dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            evt_q   <= '0;
            inten_q <= '0;
            mode_q  <= DET_DIRECT;
        end else begin
            latch_q <= (latch_q & ~latch_clr) | match_v;
            evt_q   <= (evt_q & ~evt_clr) | evt_v;
            if (wr_inten) inten_q <= bus_wdata[NUM_PINS-1:0];
            if (wr_mode)  mode_q  <= det_mode_e'(bus_wdata[0]);
        end
    end

    assign pin_out   = out_v;
    assign evt_pulse = evt_v;
    assign detect    = (mode_q == DET_LATCHED) ? |latch_q : |match_v;
    assign irq       = |(evt_q & inten_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_OUT:   bus_rdata[NUM_PINS-1:0] = out_v;
            A_IN:    bus_rdata[NUM_PINS-1:0] = sync_lvl;
            A_LATCH: bus_rdata[NUM_PINS-1:0] = latch_q;
            A_EVT:   bus_rdata[NUM_PINS-1:0] = evt_q;
            A_INTEN: bus_rdata[NUM_PINS-1:0] = inten_q;
            A_MODE:  bus_rdata[0]            = mode_q;
            default: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (bus_addr == ADDR_W'(OFS_CFG + p))
                        bus_rdata[CFG_W-1:0] = cfg_q[p];
                end
            end
        endcase
    end

    AST_LATCH_CATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(match_v)) == $past(match_v))); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_latch |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R4
    AST_EVT_PENDING: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_q & $past(evt_v)) == $past(evt_v))); // R8
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((|(evt_v & inten_q)) && !wr_inten) |=> irq); // R9

endmodule

// File: tb/gpio_sense_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_sense_unit_tb_top;
    localparam int N = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, evt_pulse;
    logic [N-1:0]  task_set = '0, task_clr = '0, task_tgl = '0;
    logic          detect, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_sense_unit dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .task_set(task_set),
        .task_clr(task_clr), .task_tgl(task_tgl), .evt_pulse(evt_pulse),
        .detect(detect), .irq(irq)
    );

    // reference model state
    logic [N-1:0] m_s1, m_s2, m_prev, m_out, m_latch, m_evt, m_inten;
    logic         m_mode;
    logic [4:0]   m_cfg [N];

    function automatic logic [N-1:0] exp_match();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            if (m_cfg[i][2:1] == 2'd1) r[i] = m_s2[i];
            else if (m_cfg[i][2:1] == 2'd2) r[i] = !m_s2[i];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_evt();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            case (m_cfg[i][4:3])
                2'd1: r[i] = m_s2[i] && !m_prev[i];
                2'd2: r[i] = !m_s2[i] && m_prev[i];
                2'd3: r[i] = m_s2[i] != m_prev[i];
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_oe();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = m_cfg[i][0];
        return r;
    endfunction

    function automatic logic [31:0] exp_rdata(logic [AW-1:0] a);
        case (a)
            6'd0: return m_out;
            6'd1: return m_s2;
            6'd2: return m_latch;
            6'd3: return m_evt;
            6'd4: return m_inten;
            6'd5: return {31'd0, m_mode};
            default: return (a >= 6'd32) ? {27'd0, m_cfg[a - 6'd32]} : 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(logic [AW-1:0] a);
        case (a)
            6'd0: return "R10";
            6'd1: return "R2";
            6'd2: return "R4 R5";
            6'd3: return "R8";
            6'd4: return "R9";
            6'd5: return "R6";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_out <= '0;
            m_latch <= '0; m_evt <= '0; m_inten <= '0; m_mode <= 1'b0;
            for (int i = 0; i < N; i++) m_cfg[i] <= '0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            for (int i = 0; i < N; i++) begin
                if (task_set[i]) m_out[i] <= 1'b1;
                else if (task_clr[i]) m_out[i] <= 1'b0;
                else if (task_tgl[i]) m_out[i] <= !m_out[i];
                else if (bus_we && bus_addr == 6'd0) m_out[i] <= bus_wdata[i];
                if (bus_we && bus_addr == 6'(32 + i)) m_cfg[i] <= bus_wdata[4:0];
            end
            m_latch <= (m_latch & ~((bus_we && bus_addr == 6'd2) ? bus_wdata : 32'd0)) | exp_match();
            m_evt   <= (m_evt & ~((bus_we && bus_addr == 6'd3) ? bus_wdata : 32'd0)) | exp_evt();
            if (bus_we && bus_addr == 6'd4) m_inten <= bus_wdata;
            if (bus_we && bus_addr == 6'd5) m_mode <= bus_wdata[0];
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R10", "pin_out", pin_out, m_out);
            check("R10", "pin_oe", pin_oe, exp_oe());
            check("R7", "evt_pulse", evt_pulse, exp_evt());
            check(m_mode ? "R6" : "R3", "detect", {31'd0, detect},
                  {31'd0, m_mode ? |m_latch : |exp_match()});
            check("R9", "irq", {31'd0, irq}, {31'd0, |(m_evt & m_inten)});
            check(rd_tag(bus_addr), "rdata", bus_rdata, exp_rdata(bus_addr));
        end
    end

    task automatic drive(logic we, logic [AW-1:0] a, logic [31:0] d,
                         logic [N-1:0] pins, logic [N-1:0] ts,
                         logic [N-1:0] tc, logic [N-1:0] tt);
        @(negedge clk);
        #1;
        bus_we = we; bus_addr = a; bus_wdata = d; pin_in = pins;
        task_set = ts; task_clr = tc; task_tgl = tt;
    endtask

    task automatic idle(logic [AW-1:0] a, int n);
        for (int k = 0; k < n; k++) drive(1'b0, a, 32'd0, pin_in, '0, '0, '0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        drive(1'b1, a, d, pin_in, '0, '0, '0);
    endtask

    task automatic set_pins(logic [N-1:0] p, logic [AW-1:0] a);
        drive(1'b0, a, 32'd0, p, '0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "pin_out rst", pin_out, 32'd0);
        check("R1", "pin_oe rst", pin_oe, 32'd0);
        check("R1", "evt rst", evt_pulse, 32'd0);
        check("R1", "detect/irq rst", {30'd0, detect, irq}, 32'd0);
        check("R1", "rdata rst", bus_rdata, 32'd0);
        #1 rst = 1'b0;
        idle(6'd2, 3);

        // configuration: pin0 high/rise, pin1 low/fall, pin2 off/any,
        // pin3 code3/none, pin4 high/any output
        wr(6'd32, 32'b01_01_0);
        wr(6'd33, 32'b10_10_0);
        wr(6'd34, 32'b11_00_0);
        wr(6'd35, 32'b00_11_0);
        wr(6'd36, 32'b11_01_1);
        wr(6'd4, 32'hFFFF_FFFF);
        // R3: pin1 low-sense matches at once; observe detect and latch
        idle(6'd2, 3);
        wr(6'd2, 32'h2);                 // R5: clear while still matching
        idle(6'd2, 2);
        set_pins(32'h0000_0002, 6'd1);   // R2: pin1 high -> match ends
        idle(6'd1, 3);
        wr(6'd2, 32'hFFFF_FFFF);         // R5: clear after match ended
        idle(6'd2, 2);
        set_pins(32'h0000_0007, 6'd3);   // R7: rising on pin0, pin2
        idle(6'd3, 4);
        wr(6'd3, 32'hFFFF_FFFF);         // R8: clear pending
        idle(6'd3, 2);
        set_pins(32'h0000_0004, 6'd3);   // R7: falling on pin0, pin1
        idle(6'd3, 1);
        // R8: clear in the cycle the pulse arrives (set wins)
        wr(6'd3, 32'hFFFF_FFFF);
        idle(6'd3, 3);
        set_pins(32'h0000_000F, 6'd2);   // pin3 code3 never latches
        idle(6'd2, 4);
        wr(6'd5, 32'd1);                 // R6: latched detect
        idle(6'd2, 2);
        wr(6'd2, 32'hFFFF_FFFF);
        idle(6'd5, 3);
        wr(6'd5, 32'd0);
        // R10: task priorities and override of bus write
        drive(1'b1, 6'd0, 32'h0000_00F0, pin_in, '0, '0, '0);
        drive(1'b1, 6'd0, 32'h0000_0000, pin_in, 32'h10, 32'h30, 32'h70);
        drive(1'b1, 6'd0, 32'hFFFF_FFFF, pin_in, '0, 32'h20, 32'h40);
        drive(1'b0, 6'd0, 32'h0, pin_in, '0, '0, 32'hFF);
        idle(6'd0, 2);
        wr(6'd4, 32'h0);                 // R9: masked irq
        idle(6'd3, 2);

        // constrained random phase
        for (int k = 0; k < 6000; k++) begin
            logic [N-1:0] pins, ts, tc, tt;
            logic [AW-1:0] a;
            logic [31:0] d;
            logic we;
            pins = pin_in ^ ($urandom & $urandom & $urandom);
            ts = ($urandom % 8 == 0) ? ($urandom & $urandom & $urandom) : '0;
            tc = ($urandom % 8 == 0) ? ($urandom & $urandom & $urandom) : '0;
            tt = ($urandom % 8 == 0) ? ($urandom & $urandom) : '0;
            case ($urandom % 4)
                0: a = 6'($urandom % 6);
                1: a = 6'd2;
                2: a = 6'd3;
                default: a = 6'(32 + $urandom % 32);
            endcase
            we = ($urandom % 4 == 0);
            d = $urandom;
            drive(we, a, d, pins, ts, tc, tt);
        end
        idle(6'd2, 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule